// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a translation miss by reading a four-level radix page table in memory. When it is idle it accepts one miss, made of the root table base and the virtual address that missed. It then issues one read per level through a request/acknowledge/response memory port. Each entry it reads either points to the next table or ends the walk.

A walk ends in one of two ways. It may find a valid leaf. The leaf can be a 4 KiB page at the last level, or a 1 GiB or 2 MiB page when the large-page flag is set in the second- or third-level entry. In that case the walker sends the physical frame, the combined permissions and a page-size code to the translation cache fill port. Otherwise it meets an entry whose present bit is clear and raises a page fault, and no fill is made. Only one walk is in flight at a time.

Top module: `page_walker`

## Requirements
- R1: After reset, `miss_ready_o` is 1 and `mem_req_o`, `fill_valid_o` and `fault_o` are all 0.
- R2: Walk level n (n = 0..3) reads the entry at address `base + 8*idx`. The index idx is taken from virtual address bits 47:39, 38:30, 29:21 and 20:12 for n = 0, 1, 2 and 3. Level 0 uses the root base. Each deeper level uses entry bits PA_W-1:12 of the previous entry, shifted left by 12.
- R3: `mem_req_o` stays high, with `mem_addr_o` unchanged, until a cycle in which `mem_ack_i` is high.
- R4: An entry with bit 0 (present) clear, at any level, ends the walk. `fault_o` pulses, there is no fill and no further read.
- R5: If no earlier level ends the walk, the last-level entry gives a 4 KiB page after exactly 4 reads. `fill_frame_o` is entry bits PA_W-1:12 and `fill_size_o` is 0.
- R6: Bit 7 set in a present level-1 entry ends the walk after 2 reads with a 1 GiB page. `fill_size_o` is 2 and `fill_frame_o` is (entry bits PA_W-1:30 shifted left by 30, plus VA bits 29:0) >> 12.
- R7: Bit 7 set in a present level-2 entry ends the walk after 3 reads with a 2 MiB page. `fill_size_o` is 1 and `fill_frame_o` is (entry bits PA_W-1:21 shifted left by 21, plus VA bits 20:0) >> 12.
- R8: Bit 7 in a level-0 entry has no effect, and the walk continues to the next level.
- R9: `fill_wr_o` is the AND of bit 1 and `fill_usr_o` is the AND of bit 2, taken over every entry read in the walk.
- R10: `miss_ready_o` is 0 while a walk is in progress. A miss presented then is ignored and starts no reads.
- R11: `fill_valid_o` and `fault_o` never rise together. Each is a one-cycle pulse, in the cycle after the final `mem_rvalid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| miss_valid_i | input | 1 | Translation miss request |
| miss_ready_o | output | 1 | Walker idle, miss accepted |
| miss_vaddr_i | input | VA_W | Virtual address that missed |
| root_base_i | input | PA_W | Physical base of the top-level table (4 KiB aligned) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | PA_W | Entry address |
| mem_ack_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Table entry |
| fill_valid_o | output | 1 | Translation fill pulse |
| fill_frame_o | output | PA_W-12 | Physical 4 KiB frame number of the address |
| fill_size_o | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| fill_wr_o | output | 1 | Writable permission |
| fill_usr_o | output | 1 | User permission |
| fault_o | output | 1 | Page fault pulse |

## Verification
The bench builds table chains in a sparse memory model. It checks every entry address of every walk against its own index arithmetic, so a swapped VA slice or a missing times-8 scale shows up as a wrong read address.

For large pages, the bench places bit 7 at levels 0, 1 and 2. A decoder that tests the wrong level would cut the walk short at the top or run past a huge page. For those pages the low frame bits come from the VA, so taking them from the entry would give a wrong frame.

Faults at the first and third level check that the walk stops with no fill. A cleared write or user bit in a middle entry checks that permissions are combined across all levels rather than taken from the leaf alone. A stalled acknowledge checks that the request is held with a steady address. A miss presented mid-walk checks that the walker does not start a second walk.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int ENTRY_W  = 64;
  localparam int IDX_W    = 9;
  localparam int PG_SHIFT = 12;

  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2
  } pg_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walk_st_e;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
  import pw_pkg::*;
#(
  parameter int PA_W   = 40,
  parameter int LEVELS = 4,
  localparam int LVL_W   = $clog2(LEVELS),
  localparam int VPN_W   = IDX_W * LEVELS,
  localparam int FRAME_W = PA_W - PG_SHIFT
) (
  input  logic [VPN_W-1:0]   vpn_i,
  input  logic [LVL_W-1:0]   level_i,
  input  logic [FRAME_W-1:0] base_i,
  output logic [PA_W-1:0]    addr_o
);
  logic [IDX_W-1:0] idx_arr [LEVELS];

  // level 0 takes the most significant slice
  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx_arr[l] = vpn_i[IDX_W*(LEVELS-l)-1 -: IDX_W];
  end

  // table is 4 KiB aligned: base + 8*idx is a concatenation
  assign addr_o = {base_i, idx_arr[level_i], 3'b000};
endmodule

// File: rtl/pw_entry_decode.sv
module pw_entry_decode
  import pw_pkg::*;
#(
  parameter int PA_W   = 40,
  parameter int LEVELS = 4,
  localparam int LVL_W   = $clog2(LEVELS),
  localparam int FRAME_W = PA_W - PG_SHIFT,
  localparam int SH_2M   = PG_SHIFT + IDX_W,
  localparam int SH_1G   = PG_SHIFT + 2*IDX_W
) (
  input  logic [ENTRY_W-1:0]   entry_i,
  input  logic [LVL_W-1:0]     level_i,
  input  logic [2*IDX_W-1:0]   vpn_lo_i,
  output logic                 present_o,
  output logic                 leaf_o,
  output pg_size_e             size_o,
  output logic [FRAME_W-1:0]   next_base_o,
  output logic [FRAME_W-1:0]   leaf_frame_o,
  output logic                 wr_o,
  output logic                 usr_o
);
  logic is_last, is_l1, is_l2, big;

  assign is_last = (level_i == LVL_W'(LEVELS-1));
  assign is_l1   = (level_i == LVL_W'(1));
  assign is_l2   = (level_i == LVL_W'(2));
  assign big     = entry_i[7];

  assign present_o   = entry_i[0];
  assign wr_o        = entry_i[1];
  assign usr_o       = entry_i[2];
  assign next_base_o = entry_i[PA_W-1:PG_SHIFT];
  assign leaf_o      = is_last || (big && (is_l1 || is_l2));

  always_comb begin
    size_o       = PG_4K;
    leaf_frame_o = entry_i[PA_W-1:PG_SHIFT];
    if (big && is_l1) begin
      size_o       = PG_1G;
      leaf_frame_o = {entry_i[PA_W-1:SH_1G], vpn_lo_i};
    end else if (big && is_l2) begin
      size_o       = PG_2M;
      leaf_frame_o = {entry_i[PA_W-1:SH_2M], vpn_lo_i[IDX_W-1:0]};
    end
  end

  logic unused_bits;
  assign unused_bits = ^{entry_i[ENTRY_W-1:PA_W], entry_i[PG_SHIFT-1:8], entry_i[6:3]};
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 40,
  parameter int LEVELS = 4,
  localparam int LVL_W   = $clog2(LEVELS),
  localparam int VPN_W   = IDX_W * LEVELS,
  localparam int FRAME_W = PA_W - PG_SHIFT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                miss_valid_i,
  output logic                miss_ready_o,
  input  logic [VA_W-1:0]     miss_vaddr_i,
  input  logic [PA_W-1:0]     root_base_i,
  output logic                mem_req_o,
  output logic [PA_W-1:0]     mem_addr_o,
  input  logic                mem_ack_i,
  input  logic                mem_rvalid_i,
  input  logic [ENTRY_W-1:0]  mem_rdata_i,
  output logic                fill_valid_o,
  output logic [FRAME_W-1:0]  fill_frame_o,
  output logic [1:0]          fill_size_o,
  output logic                fill_wr_o,
  output logic                fill_usr_o,
  output logic                fault_o
);
  walk_st_e           st_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [VPN_W-1:0]   vpn_q;
  logic [FRAME_W-1:0] base_q;
  logic               wr_q, usr_q;

  logic               ent_present, ent_leaf, ent_wr, ent_usr;
  pg_size_e           ent_size;
  logic [FRAME_W-1:0] ent_next, ent_frame;

  pw_addr_gen #(.PA_W(PA_W), .LEVELS(LEVELS)) i_addr_gen (
    .vpn_i   (vpn_q),
    .level_i (lvl_q),
    .base_i  (base_q),
    .addr_o  (mem_addr_o)
  );

  pw_entry_decode #(.PA_W(PA_W), .LEVELS(LEVELS)) i_decode (
    .entry_i      (mem_rdata_i),
    .level_i      (lvl_q),
    .vpn_lo_i     (vpn_q[2*IDX_W-1:0]),
    .present_o    (ent_present),
    .leaf_o       (ent_leaf),
    .size_o       (ent_size),
    .next_base_o  (ent_next),
    .leaf_frame_o (ent_frame),
    .wr_o         (ent_wr),
    .usr_o        (ent_usr)
  );

  assign miss_ready_o = (st_q == ST_IDLE);
  assign mem_req_o    = (st_q == ST_REQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      lvl_q        <= '0;
      vpn_q        <= '0;
      base_q       <= '0;
      wr_q         <= 1'b0;
      usr_q        <= 1'b0;
      fill_valid_o <= 1'b0;
      fault_o      <= 1'b0;
      fill_frame_o <= '0;
      fill_size_o  <= PG_4K;
      fill_wr_o    <= 1'b0;
      fill_usr_o   <= 1'b0;
    end else begin
      fill_valid_o <= 1'b0;
      fault_o      <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (miss_valid_i) begin
          vpn_q  <= miss_vaddr_i[PG_SHIFT +: VPN_W];
          base_q <= root_base_i[PA_W-1:PG_SHIFT];
          lvl_q  <= '0;
          wr_q   <= 1'b1;
          usr_q  <= 1'b1;
          st_q   <= ST_REQ;
        end
        ST_REQ: if (mem_ack_i) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          if (!ent_present) begin
            fault_o <= 1'b1;
            st_q    <= ST_IDLE;
          end else if (ent_leaf) begin
            fill_valid_o <= 1'b1;
            fill_frame_o <= ent_frame;
            fill_size_o  <= ent_size;
            fill_wr_o    <= wr_q & ent_wr;
            fill_usr_o   <= usr_q & ent_usr;
            st_q         <= ST_IDLE;
          end else begin
            base_q <= ent_next;
            lvl_q  <= lvl_q + LVL_W'(1);
            wr_q   <= wr_q & ent_wr;
            usr_q  <= usr_q & ent_usr;
            st_q   <= ST_REQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic unused_va;
  assign unused_va = ^{miss_vaddr_i[PG_SHIFT-1:0], root_base_i[PG_SHIFT-1:0]};

  // read counter for the per-walk bound check
  logic [LVL_W:0] rd_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               rd_cnt_q <= '0;
    else if (miss_valid_i && miss_ready_o)     rd_cnt_q <= '0;
    else if (mem_req_o && mem_ack_i)           rd_cnt_q <= rd_cnt_q + 1'b1;
  end

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
  // R11
  out_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_valid_o && fault_o));
  // R11
  pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_o || fault_o) |=> !fill_valid_o && !fault_o);
  // R5
  read_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt_q <= (LVL_W+1)'(LEVELS));
  // R6
  size_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> fill_size_o != 2'd3);
  // R10
  busy_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !miss_ready_o);
endmodule

// File: tb/test_page_walker.sv
module test_page_walker;
  localparam int VA_W = 48;
  localparam int PA_W = 40;
  localparam int FW   = PA_W - 12;
  localparam int NMEM = 8;

  logic clk = 0, rst_n = 0;
  logic miss_valid = 0;
  logic [VA_W-1:0] miss_vaddr = '0;
  logic [PA_W-1:0] root_base = '0;
  logic mem_ack = 0, mem_rvalid = 0;
  logic [63:0] mem_rdata = '0;
  logic miss_ready, mem_req, fill_valid, fault, fill_wr, fill_usr;
  logic [PA_W-1:0] mem_addr;
  logic [FW-1:0] fill_frame;
  logic [1:0] fill_size;

  always #5 clk = ~clk;

  page_walker i_page_walker (
    .clk_i(clk), .rst_ni(rst_n), .miss_valid_i(miss_valid), .miss_ready_o(miss_ready),
    .miss_vaddr_i(miss_vaddr), .root_base_i(root_base), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .fill_valid_o(fill_valid), .fill_frame_o(fill_frame),
    .fill_size_o(fill_size), .fill_wr_o(fill_wr), .fill_usr_o(fill_usr), .fault_o(fault)
  );

  int n_chk = 0, n_fail = 0;
  logic [63:0] mem_a [NMEM];
  logic [63:0] mem_d [NMEM];
  logic [63:0] log_a [16];
  int n_reads = 0;
  int ack_delay = 0, rd_lat = 1;
  int hold_err = 0;

  logic got_fill, got_fault, got_wr, got_usr;
  logic [63:0] got_frame;
  logic [1:0] got_size;
  int pulse_len;

  localparam logic [63:0] P = 64'h1, W = 64'h2, U = 64'h4, PS = 64'h80;
  localparam logic [63:0] T0 = 64'h10_0000, T1 = 64'h20_0000, T2 = 64'h30_0000, T3 = 64'h40_0000;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] lookup(input logic [63:0] a);
    for (int i = 0; i < NMEM; i++) if (mem_a[i] == a) return mem_d[i];
    return 64'h0;
  endfunction

  function automatic logic [63:0] ent_addr(input logic [63:0] base, input logic [63:0] va, input int lvl);
    logic [63:0] idx;
    idx = (va >> (39 - 9*lvl)) % 512;
    return base + 8*idx;
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < NMEM; i++) begin mem_a[i] = 64'hFFFF_FFFF_FFFF_FFFF; mem_d[i] = '0; end
  endtask

  // standard chain from T0; per-level flags, leaf data given
  task automatic chain(input logic [63:0] va, input logic [63:0] f0, input logic [63:0] f1,
                       input logic [63:0] f2, input logic [63:0] leaf);
    clear_mem();
    mem_a[0] = ent_addr(T0, va, 0); mem_d[0] = T1 | f0;
    mem_a[1] = ent_addr(T1, va, 1); mem_d[1] = T2 | f1;
    mem_a[2] = ent_addr(T2, va, 2); mem_d[2] = T3 | f2;
    mem_a[3] = ent_addr(T3, va, 3); mem_d[3] = leaf;
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [PA_W-1:0] a0;
        a0 = mem_addr;
        if (n_reads < 16) log_a[n_reads] = 64'(a0);
        n_reads++;
        for (int k = 0; k < ack_delay; k++) begin
          @(negedge clk);
          if (!mem_req || mem_addr != a0) hold_err++;
        end
        mem_ack = 1;
        @(negedge clk);
        mem_ack = 0;
        for (int k = 0; k < rd_lat; k++) @(negedge clk);
        mem_rvalid = 1;
        mem_rdata = lookup(64'(a0));
        @(negedge clk);
        mem_rvalid = 0;
      end
    end
  end

  task automatic do_walk(input logic [63:0] va, input int poke);
    int t;
    n_reads = 0;
    got_fill = 0; got_fault = 0;
    @(negedge clk);
    root_base = PA_W'(T0);
    miss_vaddr = VA_W'(va);
    miss_valid = 1;
    @(negedge clk);
    miss_valid = 0;
    if (poke > 0) begin
      for (int k = 0; k < poke; k++) begin
        miss_vaddr = ~VA_W'(va);
        miss_valid = 1;
        @(negedge clk);
        chk(miss_ready == 0, "R10 busy ready", 64'(miss_ready), 0);
      end
      miss_valid = 0;
    end
    t = 0;
    while (!(fill_valid || fault) && t < 400) begin @(negedge clk); t++; end
    chk(t < 400, "R11 walk completes", 64'(t), 0);
    got_fill = fill_valid; got_fault = fault;
    got_frame = 64'(fill_frame); got_size = fill_size;
    got_wr = fill_wr; got_usr = fill_usr;
    @(negedge clk);
    chk(!fill_valid && !fault, "R11 one-cycle pulse", 64'({fill_valid, fault}), 0);
  endtask

  task automatic chk_addrs(input logic [63:0] va, input int n, input string req);
    logic [63:0] b [4];
    b[0] = T0; b[1] = T1; b[2] = T2; b[3] = T3;
    chk(n_reads == n, req, 64'(n_reads), 64'(n));
    for (int l = 0; l < n && l < 4; l++)
      chk(log_a[l] == ent_addr(b[l], va, l), "R2 entry address", log_a[l], ent_addr(b[l], va, l));
  endtask

  task automatic t_reset();
    chk(miss_ready == 1, "R1 ready", 64'(miss_ready), 1);
    chk({mem_req, fill_valid, fault} == 3'b000, "R1 outputs idle", 64'({mem_req, fill_valid, fault}), 0);
  endtask

  task automatic t_4k();
    logic [63:0] va = 64'h0000_8040_6018_7ABC;
    chain(va, P|W|U, P|W|U, P|W|U, 64'h00_ABCD_E000 | P|W|U);
    do_walk(va, 0);
    chk_addrs(va, 4, "R5 four reads");
    chk(got_fill && !got_fault, "R5 fill", 64'({got_fill, got_fault}), 2);
    chk(got_frame == 64'h0ABCDE, "R5 frame", got_frame, 64'h0ABCDE);
    chk(got_size == 0, "R5 size", 64'(got_size), 0);
    chk(got_wr && got_usr, "R9 all perms", 64'({got_wr, got_usr}), 3);
  endtask

  task automatic t_perm();
    logic [63:0] va = 64'h0000_7FC0_0020_1000;
    chain(va, P|W|U, P|U, P|W, 64'h00_1234_5000 | P|W|U);
    do_walk(va, 0);
    chk_addrs(va, 4, "R5 four reads perm");
    chk(!got_wr, "R9 write cleared mid-walk", 64'(got_wr), 0);
    chk(!got_usr, "R9 user cleared mid-walk", 64'(got_usr), 0);
    chain(va, P|W|U, P|W|U, P|W|U, 64'h00_1234_5000 | P|U);
    do_walk(va, 0);
    chk(!got_wr && got_usr, "R9 leaf-only write clear", 64'({got_wr, got_usr}), 1);
  endtask

  task automatic t_1g();
    logic [63:0] va = 64'h0000_0123_5678_9ABC;
    logic [63:0] pb = 64'h80_4000_0000;
    logic [63:0] ef;
    chain(va, P|W|U, 0, 0, 0);
    mem_d[1] = pb | PS | P | W;
    ef = (pb + (va % 64'h4000_0000)) >> 12;
    do_walk(va, 0);
    chk_addrs(va, 2, "R6 two reads");
    chk(got_fill, "R6 fill", 64'(got_fill), 1);
    chk(got_size == 2, "R6 size", 64'(got_size), 2);
    chk(got_frame == ef, "R6 frame", got_frame, ef);
    chk(got_wr && !got_usr, "R9 1G perms", 64'({got_wr, got_usr}), 2);
  endtask

  task automatic t_2m();
    logic [63:0] va = 64'h0000_0042_1F3F_F123;
    logic [63:0] pb = 64'h12_3460_0000;
    logic [63:0] ef;
    chain(va, P|W|U, P|W|U, 0, 0);
    mem_d[2] = pb | PS | P | W | U;
    ef = (pb + (va % 64'h20_0000)) >> 12;
    do_walk(va, 0);
    chk_addrs(va, 3, "R7 three reads");
    chk(got_fill && got_size == 1, "R7 size", 64'(got_size), 1);
    chk(got_frame == ef, "R7 frame", got_frame, ef);
  endtask

  task automatic t_top_ps();
    logic [63:0] va = 64'h0000_1000_0000_0000;
    chain(va, P|W|U|PS, P|W|U, P|W|U, 64'h00_0055_5000 | P|W|U);
    do_walk(va, 0);
    chk_addrs(va, 4, "R8 top bit7 ignored");
    chk(got_fill && got_size == 0, "R8 4K result", 64'(got_size), 0);
  endtask

  task automatic t_fault0();
    logic [63:0] va = 64'h0000_FFFF_FFFF_F000;
    chain(va, W|U, P|W|U, P|W|U, 64'h00_1111_1000 | P);
    do_walk(va, 0);
    chk_addrs(va, 1, "R4 one read");
    chk(got_fault && !got_fill, "R4 fault top", 64'({got_fill, got_fault}), 1);
  endtask

  task automatic t_fault2();
    logic [63:0] va = 64'h0000_0000_4020_3000;
    chain(va, P|W|U, P|W|U, W|U|PS, 64'h00_1111_1000 | P);
    do_walk(va, 0);
    chk_addrs(va, 3, "R4 three reads");
    chk(got_fault && !got_fill, "R4 fault dir", 64'({got_fill, got_fault}), 1);
  endtask

  task automatic t_stall_busy();
    logic [63:0] va = 64'h0000_3456_789A_B000;
    int nr;
    chain(va, P|W|U, P|W|U, P|W|U, 64'h00_0987_6000 | P|W|U);
    ack_delay = 4; rd_lat = 2; hold_err = 0;
    do_walk(va, 3);
    chk(hold_err == 0, "R3 request held stable", 64'(hold_err), 0);
    chk_addrs(va, 4, "R10 single walk");
    chk(got_frame == 64'h09876, "R5 frame stalled", got_frame, 64'h09876);
    nr = n_reads;
    repeat (8) @(negedge clk);
    chk(n_reads == nr && !mem_req, "R10 poke ignored", 64'(n_reads), 64'(nr));
    ack_delay = 0; rd_lat = 1;
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_4k();
        t_perm();
        t_1g();
        t_2m();
        t_top_ps();
        t_fault0();
        t_fault2();
        t_stall_busy();
      end
      begin
        repeat (50000) @(posedge clk);
        wd = 1;
      end
    join_any
    if (wd) chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule